// File: doc/BRIEF.md
# Interrupt Latch and Mask Controller

This block gathers interrupt requests from four external pins and two internal timer tick sources. It records them in a pending latch and presents one registered request, together with the index of the source that should be serviced first. Software reaches it through a small word-addressed register port. The pending latch can be rewritten as a whole. It can also be changed bit by bit through two write-only alias addresses, one that only sets bits and one that only clears bits, so that no read-modify-write sequence is needed.

Each pin passes through a two-flop synchronizer. A control register sets each pin to latch on a rising edge or to track its level, and it holds a run bit for each timer source. A separate sequencer word holds the global interrupt enable, which gates the request output, and an exception enable bit that is stored and read back. An acknowledge input clears the pending bit of the source currently reported, provided that source is edge-type.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the pending latch, mask, control word and sequencer word read as zero, and `irq_req` is low.
- R2: A write to address 1 (set alias) sets each edge-type pending bit whose data bit is one. Bits written with zero keep their value.
- R3: A write to address 2 (clear alias) clears each edge-type pending bit whose data bit is one. Bits written with zero keep their value.
- R4: A write to address 0 replaces all edge-type pending bits. Reads of addresses 0, 1 and 2 return the pending latch, with pins in bits 3:0 and timers 0 and 1 in bits 4 and 5. Bits above 5 read as zero.
- R5: Address 4 is the control word. Bit n (3:0) set to one puts pin n in edge mode, and zero puts it in level mode. Bits 4 and 5 are the run enables for timer 0 and timer 1. All other bits read as zero and ignore writes.
- R6: Address 5 is the sequencer word. Bit 2 is the global enable and bit 3 the exception enable, and all other bits read as zero. While bit 2 is zero, `irq_req` is low.
- R7: A pin in edge mode sets its pending bit on a synchronized rising edge. The bit stays set after the pin falls.
- R8: A pin in level mode has a pending bit equal to its synchronized level. Software writes and acknowledge do not change that bit.
- R9: A tick on timer t sets pending bit 4+t only while that timer's run bit is one.
- R10: Address 3 is the mask, where a one enables a source. `irq_id` is the lowest index that is both pending and enabled. `irq_req` is high when such a source exists and the global enable is set. Both outputs are registered.
- R11: An `ack` pulse while `irq_req` is high clears the pending bit of the source in `irq_id` when that source is edge-type.
- R12: A hardware event (edge-mode pin rise or enabled timer tick) in the same cycle as a clear-alias or direct write to the same bit leaves the bit set. A set-alias write together with an event also leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_irq | input | 4 | Asynchronous external interrupt pins |
| tmr_tick | input | 2 | Single-cycle timer tick pulses, timer 0 in bit 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| ack | input | 1 | Service acknowledge for the reported source |
| irq_req | output | 1 | Registered interrupt request |
| irq_id | output | 3 | Registered index of the source to service |

## Verification
The bench goes after collisions between a timer tick and a clear-alias or set-alias write in the same cycle. A design that let software win would drop a real interrupt. It checks that level-mode bits ignore the aliases and acknowledge, because a design that latched them would keep asserting after the pin fell. It also checks that edge-mode bits survive the pin falling. It probes priority with several mask patterns and with the global enable off. A wrong encoder would report the highest index instead of the lowest, and a missing gate would raise the request while interrupts are disabled. Reserved control and sequencer bits are written with all ones and read back, so that stray storage shows up.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_PEND = 3'd0,
    RA_PSET = 3'd1,
    RA_PCLR = 3'd2,
    RA_MASK = 3'd3,
    RA_CTRL = 3'd4,
    RA_SEQ  = 3'd5
  } reg_addr_e;

  localparam int SEQ_GIE_BIT = 2;
  localparam int SEQ_EXC_BIT = 3;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_all,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [N-1:0]     wdata,
  input  logic [N-1:0]     lvl_mask,
  input  logic [N-1:0]     lvl_val,
  input  logic [N-1:0]     event_i,
  input  logic             ack_en,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N-1:0]     pend_o
);
  logic [N-1:0] nxt;

  always_comb begin
    nxt = pend_o;
    if (ack_en && !lvl_mask[ack_idx]) nxt[ack_idx] = 1'b0;
    if (wr_all) nxt = wdata;
    if (wr_set) nxt = nxt | wdata;
    if (wr_clr) nxt = nxt & ~wdata;
    nxt = nxt | event_i;
    nxt = (nxt & ~lvl_mask) | (lvl_val & lvl_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= nxt;
  end

  assert_set_alias_R2: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((pend_o & $past(wdata & ~lvl_mask)) == $past(wdata & ~lvl_mask)));

  assert_clear_alias_R3: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((pend_o & $past(wdata & ~lvl_mask & ~event_i)) == '0));

  assert_level_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & $past(lvl_mask)) == ($past(lvl_val) & $past(lvl_mask))));

  assert_ack_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_en && !lvl_mask[ack_idx] && !event_i[ack_idx] && !wr_all && !wr_set)
    |=> !pend_o[$past(ack_idx)]);

  assert_event_wins_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & $past(event_i)) == $past(event_i)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     act,
  input  logic             gie,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_id
);
  logic [IDX_W-1:0] id_c;
  logic             hit_c;
  logic [N-1:0]     act_q;

  always_comb begin
    id_c  = '0;
    hit_c = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        id_c  = IDX_W'(i);
        hit_c = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_id  <= '0;
      act_q   <= '0;
    end else begin
      irq_req <= hit_c & gie;
      irq_id  <= id_c;
      act_q   <= act;
    end
  end

  assert_gie_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_req);

  assert_req_raise_R10: assert property (@(posedge clk) disable iff (rst)
    (gie && (act != '0)) |=> irq_req);

  assert_lowest_index_R10: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (act_q[irq_id] && ((act_q & ((N'(1) << irq_id) - N'(1))) == '0)));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int NUM_TIMERS  = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [NUM_PINS-1:0]                        pin_irq,
  input  logic [NUM_TIMERS-1:0]                      tmr_tick,
  input  logic                                       bus_wr,
  input  logic [REG_AW-1:0]                          bus_addr,
  input  logic [DATA_W-1:0]                          bus_wdata,
  output logic [DATA_W-1:0]                          bus_rdata,
  input  logic                                       ack,
  output logic                                       irq_req,
  output logic [$clog2(NUM_PINS+NUM_TIMERS)-1:0]     irq_id
);
  localparam int NUM_SRC = NUM_PINS + NUM_TIMERS;
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic [NUM_PINS-1:0]   pin_lvl, pin_rise;
  logic [NUM_SRC-1:0]    mask_q;
  logic [NUM_PINS-1:0]   edge_sel_q;
  logic [NUM_TIMERS-1:0] run_q;
  logic                  gie_q, exc_q;
  logic [NUM_SRC-1:0]    pend;
  logic [NUM_SRC-1:0]    lvl_mask, lvl_val, hw_event;
  logic                  wr_pend, wr_pset, wr_pclr;
  logic [DATA_W-1:0]     seq_word;
  logic                  unused_wdata;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_irq[g]),
        .lvl_o  (pin_lvl[g]),
        .rise_o (pin_rise[g])
      );
    end
  endgenerate

  assign wr_pend  = bus_wr && (bus_addr == RA_PEND);
  assign wr_pset  = bus_wr && (bus_addr == RA_PSET);
  assign wr_pclr  = bus_wr && (bus_addr == RA_PCLR);
  assign lvl_mask = {{NUM_TIMERS{1'b0}}, ~edge_sel_q};
  assign lvl_val  = {{NUM_TIMERS{1'b0}}, pin_lvl};
  assign hw_event = {tmr_tick & run_q, pin_rise & edge_sel_q};
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      edge_sel_q <= '0;
      run_q      <= '0;
      gie_q      <= 1'b0;
      exc_q      <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        RA_MASK: mask_q <= bus_wdata[NUM_SRC-1:0];
        RA_CTRL: begin
          edge_sel_q <= bus_wdata[NUM_PINS-1:0];
          run_q      <= bus_wdata[NUM_SRC-1:NUM_PINS];
        end
        RA_SEQ: begin
          gie_q <= bus_wdata[SEQ_GIE_BIT];
          exc_q <= bus_wdata[SEQ_EXC_BIT];
        end
        default: ;
      endcase
    end
  end

  irq_pend_bank #(.N(NUM_SRC), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_all   (wr_pend),
    .wr_set   (wr_pset),
    .wr_clr   (wr_pclr),
    .wdata    (bus_wdata[NUM_SRC-1:0]),
    .lvl_mask (lvl_mask),
    .lvl_val  (lvl_val),
    .event_i  (hw_event),
    .ack_en   (ack && irq_req),
    .ack_idx  (irq_id),
    .pend_o   (pend)
  );

  irq_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .act     (pend & mask_q),
    .gie     (gie_q),
    .irq_req (irq_req),
    .irq_id  (irq_id)
  );

  always_comb begin
    seq_word              = '0;
    seq_word[SEQ_GIE_BIT] = gie_q;
    seq_word[SEQ_EXC_BIT] = exc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        RA_PEND, RA_PSET, RA_PCLR: bus_rdata <= DATA_W'(pend);
        RA_MASK: bus_rdata <= DATA_W'(mask_q);
        RA_CTRL: bus_rdata <= DATA_W'({run_q, edge_sel_q});
        RA_SEQ:  bus_rdata <= seq_word;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_ctrl_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == RA_CTRL) |-> (bus_rdata[DATA_W-1:NUM_SRC] == '0));
endmodule

// File: tb/test_irq_latch_ctrl.sv
`timescale 1ns/1ps
module test_irq_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pin_irq = '0;
  logic [1:0]  tmr_tick = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_id;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk(clk), .rst(rst), .pin_irq(pin_irq), .tmr_tick(tmr_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack(ack), .irq_req(irq_req), .irq_id(irq_id)
  );

  // {is_read, addr, data, expected, requirement}
  localparam int NV = 17;
  localparam logic [71:0] VEC [0:NV-1] = '{
    {1'b0, 3'd4, 32'hFFFF_FFFF, 32'h0,  4'd5},  // R5 reserved bits
    {1'b1, 3'd4, 32'h0,         32'h3F, 4'd5},  // R5
    {1'b0, 3'd4, 32'h0000_000F, 32'h0,  4'd5},
    {1'b1, 3'd4, 32'h0,         32'h0F, 4'd5},  // R5
    {1'b0, 3'd1, 32'h0000_0005, 32'h0,  4'd2},
    {1'b1, 3'd0, 32'h0,         32'h05, 4'd2},  // R2
    {1'b0, 3'd1, 32'h0000_0030, 32'h0,  4'd2},
    {1'b1, 3'd0, 32'h0,         32'h35, 4'd2},  // R2
    {1'b0, 3'd2, 32'h0000_0011, 32'h0,  4'd3},
    {1'b1, 3'd0, 32'h0,         32'h24, 4'd3},  // R3
    {1'b0, 3'd0, 32'hFFFF_FFCA, 32'h0,  4'd4},
    {1'b1, 3'd0, 32'h0,         32'h0A, 4'd4},  // R4
    {1'b1, 3'd1, 32'h0,         32'h0A, 4'd4},  // R4 alias read
    {1'b0, 3'd3, 32'hFFFF_FFFF, 32'h0,  4'd10},
    {1'b1, 3'd3, 32'h0,         32'h3F, 4'd10}, // R10 mask width
    {1'b0, 3'd5, 32'hFFFF_FFFF, 32'h0,  4'd6},
    {1'b1, 3'd5, 32'h0,         32'h0C, 4'd6}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_req", {31'd0, irq_req}, 32'd0);
    rd(3'd0, r); check("R1 pend", r, 32'h0);
    rd(3'd3, r); check("R1 mask", r, 32'h0);
    rd(3'd4, r); check("R1 ctrl", r, 32'h0);
    rd(3'd5, r); check("R1 seq", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) begin
        rd(VEC[i][70:68], r);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), r, VEC[i][35:4]);
      end else begin
        wr(VEC[i][70:68], VEC[i][67:36]);
      end
    end

    // R10 priority: pend 0x0A, all enabled, gie on
    wait_n(2);
    check("R10 req", {31'd0, irq_req}, 32'd1);
    check("R10 id lowest", {29'd0, irq_id}, 32'd1);
    wr(3'd3, 32'h3D); wait_n(2);
    check("R10 id masked", {29'd0, irq_id}, 32'd3);
    // R11 acknowledge clears reported edge source
    pulse_ack();
    rd(3'd0, r); check("R11 ack clears", r, 32'h02);
    wait_n(2);
    check("R10 only masked pending", {31'd0, irq_req}, 32'd0);
    wr(3'd3, 32'h3F); wait_n(2);
    check("R10 req back", {31'd0, irq_req}, 32'd1);
    // R6 global enable gate
    wr(3'd5, 32'h0); wait_n(2);
    check("R6 gie off", {31'd0, irq_req}, 32'd0);
    wr(3'd5, 32'h4);

    // R12 timer tick against clear alias
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h1F);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h10; tmr_tick = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; tmr_tick = 2'b00;
    rd(3'd0, r); check("R12 tick beats clear", r, 32'h10);
    wr(3'd2, 32'h10);
    rd(3'd0, r); check("R3 clear timer bit", r, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h10; tmr_tick = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; tmr_tick = 2'b00;
    rd(3'd0, r); check("R12 set with tick", r, 32'h10);
    wr(3'd0, 32'h0);

    // R9 timer run enables
    wr(3'd4, 32'h0F);
    @(negedge clk); tmr_tick = 2'b11;
    @(negedge clk); tmr_tick = 2'b00;
    rd(3'd0, r); check("R9 stopped timers", r, 32'h0);
    wr(3'd4, 32'h2F);
    @(negedge clk); tmr_tick = 2'b11;
    @(negedge clk); tmr_tick = 2'b00;
    rd(3'd0, r); check("R9 timer1 only", r, 32'h20);
    wr(3'd0, 32'h0);

    // R7 edge mode latch
    pin_irq[2] = 1'b1; wait_n(6);
    rd(3'd0, r); check("R7 edge latched", r, 32'h04);
    pin_irq[2] = 1'b0; wait_n(6);
    rd(3'd0, r); check("R7 held after fall", r, 32'h04);
    check("R10 id edge pin", {29'd0, irq_id}, 32'd2);
    pulse_ack();
    rd(3'd0, r); check("R11 ack edge pin", r, 32'h0);

    // R8 level mode
    wr(3'd4, 32'h00); wait_n(2);
    pin_irq[0] = 1'b1; wait_n(6);
    rd(3'd0, r); check("R8 level high", r, 32'h01);
    wr(3'd2, 32'h01);
    rd(3'd0, r); check("R8 clear ignored", r, 32'h01);
    check("R10 id level", {29'd0, irq_id}, 32'd0);
    pulse_ack();
    rd(3'd0, r); check("R8 ack ignored", r, 32'h01);
    pin_irq[0] = 1'b0; wait_n(6);
    rd(3'd0, r); check("R8 level low", r, 32'h0);
    wr(3'd1, 32'h01);
    rd(3'd0, r); check("R8 set ignored", r, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule